// File: doc/BRIEF.md
# Erase-Then-Program Row Write Sequencer

This block drives a small array of non-volatile bit-cells organised as rows and columns, where every cell of a row hangs on one shared erase path. A row is written in two one-direction steps: an erase pulse on the selected row first forces every cell of that row to the low-resistance state. A program pulse then follows and switches only the columns that must hold a one into the high-resistance state. Because the erase is shared by the row, each column only needs a one-direction program driver, and no write ever reverses a current.

On the host side a write or read request is taken while `ready` is high. The block then steps through its phases on its own and raises `done` for one cycle at the end. A read precharges the sense amplifiers for one cycle, then pulls the selected word line low for one evaluate cycle with sense enabled. The column results are captured at the end of that cycle. Pulse widths are parameters given in clock cycles.

Top module: `rowwr_seq`

## Requirements
- R1: After reset and whenever idle, `ready` is 1, `done` is 0, `precharge` and `sense_en` are 0, every `erase_en`, `bl` and `sl` bit is 0 and every `wl_n` bit is 1.
- R2: An accepted write raises only `erase_en[row_addr]` (bit index equals the row number) for exactly ER_CYC consecutive cycles, starting the cycle after acceptance.
- R3: No cycle has any `erase_en` bit and any `bl`/`sl` bit high together. A nonzero write has exactly one cycle between the erase and program phases in which no erase, word line or column drive is active.
- R4: In the program phase, which lasts PR_CYC cycles, `bl` and `sl` both equal the latched write data (bit i drives column i) and only `wl_n[row]` is low.
- R5: A write whose data is all zeros skips the program phase. No `bl`, `sl` or word line is driven, and `done` follows the last erase cycle directly, so the block is busy for ER_CYC+1 cycles. A nonzero write is busy for ER_CYC+PR_CYC+2 cycles.
- R6: After a write, the addressed row of the array holds the write data, where logic 1 is the high-resistance state and 0 the low-resistance state. All other rows keep their contents.
- R7: A read is busy for three cycles: one precharge cycle with no word line low, then one evaluate cycle with `sense_en` high and only `wl_n[row]` low, then the done cycle. `rd_data` carries the sense outputs of the evaluate cycle from the done cycle onward.
- R8: `done` is high for exactly one cycle per accepted request, and `ready` is low from the cycle after acceptance through the done cycle.
- R9: A request presented while `ready` is low is not accepted and leaves the array unchanged.
- R10: When `wr_req` and `rd_req` are both high in an idle cycle, the write is taken and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write request, taken when ready is high |
| rd_req | input | 1 | Read request, taken when ready is high and wr_req is low |
| row_addr | input | ROW_W | Row selected by the request |
| wr_data | input | COLS | Data to store, one bit per column |
| sa_in | input | COLS | Sense amplifier outputs from the array |
| ready | output | 1 | Idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | COLS | Captured read data |
| erase_en | output | ROWS | Per-row shared erase enable |
| wl_n | output | ROWS | Active-low word lines |
| bl | output | COLS | Per-column program bit lines |
| sl | output | COLS | Per-column program source lines |
| precharge | output | 1 | Sense amplifier precharge |
| sense_en | output | 1 | Sense amplifier evaluate enable |

## Verification
The array is preloaded with a mixed pattern, so a read before any write shows whether the read path returns stored values or only erased ones. Writes of all zeros and of all ones show apart the skipped program phase and a full-row program. Random row writes interleaved with reads catch a wrong row decode or disturbance of neighbouring rows. A request pulsed while the block is busy, and a write and read raised together, test the acceptance rules. Pulse widths other than one are used, so that erase and program lengths can be told apart from the guard cycle.

// File: rtl/erw_pkg.sv
package erw_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_ERASE = 3'd1,
      PH_GAP   = 3'd2,
      PH_PROG  = 3'd3,
      PH_PRE   = 3'd4,
      PH_EVAL  = 3'd5,
      PH_FIN   = 3'd6
   } phase_t;

   function automatic int unsigned cnt_bits(input int unsigned max_val);
      int unsigned w;
      w = 1;
      while ((1 << w) <= max_val) w++;
      return w;
   endfunction

endpackage

// File: rtl/erw_pulse_timer.sv
module erw_pulse_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/erw_row_drv.sv
module erw_row_drv #(
   parameter int unsigned ROWS  = 4,
   parameter int unsigned ROW_W = 2
) (
   input  logic [ROW_W-1:0] row_sel,
   input  logic             erase_act,
   input  logic             wl_act,
   output logic [ROWS-1:0]  erase_en,
   output logic [ROWS-1:0]  wl_n
);

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic hit;
      assign hit         = (row_sel == ROW_W'(r));
      assign erase_en[r] = erase_act & hit;
      assign wl_n[r]     = ~(wl_act & hit);
   end

endmodule

// File: rtl/erw_col_drv.sv
module erw_col_drv #(
   parameter int unsigned COLS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [COLS-1:0] data_q,
   input  logic            prog_act,
   input  logic            capture,
   input  logic [COLS-1:0] sa_in,
   output logic [COLS-1:0] bl,
   output logic [COLS-1:0] sl,
   output logic [COLS-1:0] rd_data
);

   for (genvar c = 0; c < COLS; c++) begin : g_col
      logic cap_q;

      assign bl[c] = prog_act & data_q[c];
      assign sl[c] = prog_act & data_q[c];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cap_q <= 1'b0;
         end else if (capture) begin
            cap_q <= sa_in[c];
         end
      end

      assign rd_data[c] = cap_q;
   end

endmodule

// File: rtl/rowwr_seq.sv
module rowwr_seq
   import erw_pkg::*;
#(
   parameter int unsigned ROWS   = 4,
   parameter int unsigned COLS   = 8,
   parameter int unsigned ER_CYC = 1,
   parameter int unsigned PR_CYC = 1,
   localparam int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_req,
   input  logic             rd_req,
   input  logic [ROW_W-1:0] row_addr,
   input  logic [COLS-1:0]  wr_data,
   input  logic [COLS-1:0]  sa_in,
   output logic             ready,
   output logic             done,
   output logic [COLS-1:0]  rd_data,
   output logic [ROWS-1:0]  erase_en,
   output logic [ROWS-1:0]  wl_n,
   output logic [COLS-1:0]  bl,
   output logic [COLS-1:0]  sl,
   output logic             precharge,
   output logic             sense_en
);

   localparam int unsigned MAX_CYC = (ER_CYC > PR_CYC) ? ER_CYC : PR_CYC;
   localparam int unsigned CNT_W   = cnt_bits(MAX_CYC);

   initial begin
      if (ROWS < 2)   $error("rowwr_seq: ROWS must be at least 2");
      if (COLS < 1)   $error("rowwr_seq: COLS must be at least 1");
      if (ER_CYC < 1) $error("rowwr_seq: ER_CYC must be at least 1");
      if (PR_CYC < 1) $error("rowwr_seq: PR_CYC must be at least 1");
   end

   phase_t           ph_q, ph_d;
   logic [ROW_W-1:0] row_q;
   logic [COLS-1:0]  dat_q;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_exp;
   logic             take_wr, take_rd;

   assign take_wr = (ph_q == PH_IDLE) & wr_req;
   assign take_rd = (ph_q == PH_IDLE) & ~wr_req & rd_req;

   always_comb begin
      ph_d = ph_q;
      unique case (ph_q)
         PH_IDLE:  if (take_wr) ph_d = PH_ERASE;
                   else if (take_rd) ph_d = PH_PRE;
         PH_ERASE: if (tmr_exp) ph_d = (dat_q == '0) ? PH_FIN : PH_GAP;
         PH_GAP:   ph_d = PH_PROG;
         PH_PROG:  if (tmr_exp) ph_d = PH_FIN;
         PH_PRE:   ph_d = PH_EVAL;
         PH_EVAL:  ph_d = PH_FIN;
         PH_FIN:   ph_d = PH_IDLE;
         default:  ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         row_q <= '0;
         dat_q <= '0;
      end else begin
         ph_q <= ph_d;
         if (take_wr | take_rd) row_q <= row_addr;
         if (take_wr)           dat_q <= wr_data;
      end
   end

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      if (take_wr) begin
         tmr_load = 1'b1;
         tmr_val  = CNT_W'(ER_CYC - 1);
      end else if (ph_q == PH_GAP) begin
         tmr_load = 1'b1;
         tmr_val  = CNT_W'(PR_CYC - 1);
      end
   end

   erw_pulse_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   erw_row_drv #(.ROWS(ROWS), .ROW_W(ROW_W)) u_rows (
      .row_sel   (row_q),
      .erase_act (ph_q == PH_ERASE),
      .wl_act    ((ph_q == PH_PROG) | (ph_q == PH_EVAL)),
      .erase_en  (erase_en),
      .wl_n      (wl_n)
   );

   erw_col_drv #(.COLS(COLS)) u_cols (
      .clk      (clk),
      .rst_n    (rst_n),
      .data_q   (dat_q),
      .prog_act (ph_q == PH_PROG),
      .capture  (ph_q == PH_EVAL),
      .sa_in    (sa_in),
      .bl       (bl),
      .sl       (sl),
      .rd_data  (rd_data)
   );

   assign ready     = (ph_q == PH_IDLE);
   assign done      = (ph_q == PH_FIN);
   assign precharge = (ph_q == PH_PRE);
   assign sense_en  = (ph_q == PH_EVAL);

endmodule

// File: rtl/rowwr_seq_chk.sv
module rowwr_seq_chk #(
   parameter int unsigned ROWS = 4,
   parameter int unsigned COLS = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_req,
   input logic            rd_req,
   input logic            ready,
   input logic            done,
   input logic [ROWS-1:0] erase_en,
   input logic [ROWS-1:0] wl_n,
   input logic [COLS-1:0] bl,
   input logic [COLS-1:0] sl,
   input logic            precharge,
   input logic            sense_en
);

   // R2: at most one row erased at a time
   p_erase_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(erase_en));

   // R3: erase and column drive never overlap
   p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !((|erase_en) && ((|bl) || (|sl))));

   // R4: source lines follow bit lines
   p_bl_sl_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bl == sl);

   // R4: column drive only with a word line low
   p_prog_wl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|bl) |-> !(&wl_n));

   // R7: at most one word line low, and sensing has one
   p_wl_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~wl_n));
   p_sense_wl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sense_en |-> !(&wl_n));

   // R7: evaluate follows precharge
   p_pre_then_eval_r7: assert property (@(posedge clk) disable iff (!rst_n)
      precharge |=> sense_en);

   // R8: done is a single-cycle pulse while busy
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !ready);

   // R1: idle without request stays idle
   p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !wr_req && !rd_req) |=> ready);

   // R1: idle drives nothing
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (erase_en == '0 && (&wl_n) && bl == '0 && !sense_en && !precharge));

endmodule

bind rowwr_seq rowwr_seq_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_req    (wr_req),
   .rd_req    (rd_req),
   .ready     (ready),
   .done      (done),
   .erase_en  (erase_en),
   .wl_n      (wl_n),
   .bl        (bl),
   .sl        (sl),
   .precharge (precharge),
   .sense_en  (sense_en)
);

// File: tb/rowwr_seq_tb.sv
module rowwr_seq_tb;

   localparam int ROWS  = 4;
   localparam int COLS  = 8;
   localparam int ROW_W = 2;
   localparam int ERC   = 2;
   localparam int PRC   = 3;

   typedef struct {
      bit              is_rd;
      int              row;
      logic [COLS-1:0] data;
   } item_t;

   logic clk = 0;
   logic rst_n = 0;
   logic wr_req = 0, rd_req = 0;
   logic [ROW_W-1:0] row_addr = '0;
   logic [COLS-1:0]  wr_data = '0;
   logic [COLS-1:0]  sa_in;
   logic ready, done, precharge, sense_en;
   logic [COLS-1:0] rd_data, bl, sl;
   logic [ROWS-1:0] erase_en, wl_n;

   int total = 0, bad = 0;
   int cyc = 0;
   bit finished = 0;

   logic [COLS-1:0] cells [ROWS];
   logic [COLS-1:0] refm  [ROWS];
   item_t q[$];

   always #4 clk = ~clk;

   rowwr_seq #(.ROWS(ROWS), .COLS(COLS), .ER_CYC(ERC), .PR_CYC(PRC)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
      .row_addr(row_addr), .wr_data(wr_data), .sa_in(sa_in),
      .ready(ready), .done(done), .rd_data(rd_data), .erase_en(erase_en),
      .wl_n(wl_n), .bl(bl), .sl(sl), .precharge(precharge), .sense_en(sense_en)
   );

   // behavioural array: erase clears a row, program sets driven columns
   always @(posedge clk) begin
      for (int r = 0; r < ROWS; r++) begin
         if (erase_en[r]) cells[r] <= '0;
         else if (!wl_n[r]) cells[r] <= cells[r] | (bl & sl);
      end
   end

   always_comb begin
      sa_in = '0;
      for (int r = 0; r < ROWS; r++)
         if (sense_en && !wl_n[r]) sa_in = cells[r];
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_write(input int row, input logic [COLS-1:0] d);
      item_t it;
      while (!ready) @(negedge clk);
      wr_req = 1; row_addr = ROW_W'(row); wr_data = d;
      it.is_rd = 0; it.row = row; it.data = d;
      q.push_back(it);
      refm[row] = d;
      @(negedge clk);
      wr_req = 0;
   endtask

   task automatic do_read(input int row);
      item_t it;
      while (!ready) @(negedge clk);
      rd_req = 1; row_addr = ROW_W'(row);
      it.is_rd = 1; it.row = row; it.data = refm[row];
      q.push_back(it);
      @(negedge clk);
      rd_req = 0;
   endtask

   // monitor: per-operation phase counters, compared at done
   int busy = 0, er_n = 0, pr_n = 0, pc_n = 0, se_n = 0, gap_n = 0;
   bit seen_er = 0;
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (|erase_en) begin
            er_n++; seen_er = 1;
            if (q.size() != 0) chk(erase_en == ROWS'(1 << q[0].row), "R2 erase row", erase_en, ROWS'(1 << q[0].row));
         end
         if ((|erase_en) && (|bl)) chk(0, "R3 erase/program overlap", bl, 0);
         if (!ready && !done && erase_en == '0 && (&wl_n) && bl == '0 && !precharge && seen_er)
            gap_n++;
         if (|bl) begin
            pr_n++;
            if (q.size() != 0) begin
               chk(bl == q[0].data && sl == q[0].data, "R4 column drive", {bl, sl}, {q[0].data, q[0].data});
               chk(~wl_n == ROWS'(1 << q[0].row), "R4 program word line", ~wl_n, ROWS'(1 << q[0].row));
            end
         end
         if (precharge) begin
            pc_n++;
            chk(&wl_n, "R7 no word line in precharge", wl_n, {ROWS{1'b1}});
         end
         if (sense_en) begin
            se_n++;
            if (q.size() != 0) chk(~wl_n == ROWS'(1 << q[0].row), "R7 sense word line", ~wl_n, ROWS'(1 << q[0].row));
         end
         if (!ready) busy++;
         if (done) begin
            if (q.size() == 0) begin
               chk(0, "R8 unexpected done", 1, 0);
            end else begin
               item_t it;
               it = q.pop_front();
               if (it.is_rd) begin
                  chk(busy == 3, "R7 read busy cycles", busy, 3);
                  chk(pc_n == 1 && se_n == 1, "R7 precharge/evaluate", {pc_n[15:0], se_n[15:0]}, 32'h00010001);
                  chk(er_n == 0 && pr_n == 0, "R7 no write drive in read", er_n + pr_n, 0);
                  chk(rd_data == it.data, "R7 read data", rd_data, it.data);
               end else begin
                  chk(er_n == ERC, "R2 erase width", er_n, ERC);
                  if (it.data == '0) begin
                     chk(pr_n == 0, "R5 zero skips program", pr_n, 0);
                     chk(busy == ERC + 1, "R5 zero-write busy", busy, ERC + 1);
                  end else begin
                     chk(pr_n == PRC, "R4 program width", pr_n, PRC);
                     chk(gap_n == 1, "R3 guard cycle", gap_n, 1);
                     chk(busy == ERC + PRC + 2, "R5 write busy", busy, ERC + PRC + 2);
                  end
               end
            end
            busy = 0; er_n = 0; pr_n = 0; pc_n = 0; se_n = 0; gap_n = 0; seen_er = 0;
         end
      end
   end

   // R8: done lasts one cycle
   logic done_d = 0;
   always @(negedge clk) begin
      if (rst_n && !finished && done && done_d) chk(0, "R8 done width", 2, 1);
      done_d <= done;
   end

   task automatic check_array(input string req);
      for (int r = 0; r < ROWS; r++)
         chk(cells[r] === refm[r], req, cells[r], refm[r]);
   endtask

   task automatic drain();
      int n = 0;
      while ((q.size() != 0 || !ready) && n < 100) begin
         @(negedge clk); n++;
      end
   endtask

   initial begin
      for (int r = 0; r < ROWS; r++) begin
         cells[r] = COLS'(8'hA5 ^ (r * 8'h3C));
         refm[r]  = cells[r];
      end
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(ready == 1 && done == 0, "R1 reset handshake", {ready, done}, 2'b10);
      chk(erase_en == '0 && wl_n == '1 && bl == '0 && sl == '0, "R1 reset drives",
          {erase_en, wl_n, bl, sl}, {4'h0, 4'hF, 16'h0});
      chk(!precharge && !sense_en, "R1 reset sense", {precharge, sense_en}, 0);
      rst_n = 1;
      @(negedge clk);

      // R7: read preloaded contents
      for (int r = 0; r < ROWS; r++) do_read(r);
      drain();

      // R5 zero write, full-row write
      do_write(1, '0);
      do_write(2, '1);
      drain();
      check_array("R6 array after directed writes");
      do_read(1); do_read(2);
      drain();

      // R9: request pulsed while busy is dropped
      do_write(0, 8'h3C);
      @(negedge clk);
      chk(!ready, "R8 ready low while busy", ready, 0);
      wr_req = 1; row_addr = 2'd3; wr_data = 8'hFF;
      @(negedge clk);
      wr_req = 0;
      rd_req = 1; row_addr = 2'd3;
      @(negedge clk);
      rd_req = 0;
      drain();
      check_array("R9 busy request ignored");
      do_read(3);
      drain();

      // R10: write beats simultaneous read
      while (!ready) @(negedge clk);
      begin
         item_t it;
         wr_req = 1; rd_req = 1; row_addr = 2'd3; wr_data = 8'h81;
         it.is_rd = 0; it.row = 3; it.data = 8'h81;
         q.push_back(it);
         refm[3] = 8'h81;
         @(negedge clk);
         wr_req = 0; rd_req = 0;
      end
      drain();
      check_array("R10 write taken over read");
      do_read(3);
      drain();

      // R6: random row writes with readback
      for (int k = 0; k < 40; k++) begin
         int r;
         r = int'($urandom_range(ROWS - 1, 0));
         do_write(r, COLS'($urandom));
         if (k % 3 == 0) do_read(int'($urandom_range(ROWS - 1, 0)));
      end
      drain();
      check_array("R6 array after random writes");
      for (int r = 0; r < ROWS; r++) do_read(r);
      drain();

      chk(q.size() == 0, "R8 all requests completed", q.size(), 0);
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog: actual=%0d expected=<20000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule